// File: doc/BRIEF.md
# Paired Register File with Prefix-Sized Block Transfers

This block holds sixteen 16-bit registers. Indices 0 to 7 are the general registers that feed the ALU. Indices 8 to 15 are the pointer registers. The pointer registers pair up as (8,9), (10,11), (12,13) and (14,15) to form four 32-bit address pointers. In each pair the even index holds the high word, and the pair at indices 8 and 9 is the program counter.

A one-shot size prefix sets how many adjacent registers the next transfer covers. A transfer is either a write through the write port or a store-read taken from read port 0. The prefix also sets how that transfer's starting index is aligned, and whether it moves whole words or only low bytes.

The block has two read ports. Each returns the addressed word, the 32-bit pair that holds it, and a group of words that follows the active prefix. A separate 32-bit increment input lets instruction fetch advance the program counter without using the write port. Memory sequencing, instruction decode and the ALU sit outside this block.

Top module: `paired_regfile`

## Requirements
- R1: After reset every register reads 0, `align_err` is 0 and no prefix is pending, so transfers are single-word.
- R2: With no prefix pending, a write with `wr_en` changes only register `wr_idx`, loading word 0 of `wr_data` (bits 15:0). All other registers keep their values.
- R3: Prefix codes 0, 1, 2 and 3 make the next write fill 2, 4, 8 or 16 consecutive registers from the aligned base. Word k of `wr_data` (bits 16k+15:16k) goes to register base+k, so code 3 fills indices 0 to 15 with the general registers first.
- R4: Prefix codes 4, 5, 6 and 7 with `wr_move`=0 are byte loads covering 1, 2, 4 or 8 registers. Each register takes the low byte of its word and keeps its upper byte.
- R5: With `wr_move`=1 a byte code moves full 16-bit words, over the same count of registers as the byte load would cover.
- R6: The base of a transfer of N registers is the index with its low log2(N) bits cleared. In the cycle after a write or store-read whose index is not that base, `align_err` is 1; after any other cycle it is 0.
- R7: A prefix applies to exactly one transfer (`wr_en` or `rd_take`) and then lapses to single-word. A transfer in the same cycle as `pfx_set` uses the mode that was in force before the new prefix, and the new prefix stays pending.
- R8: Each read port p returns the register at `rd_idx[4p+3:4p]` on `rd_word[16p+15:16p]` in the same cycle.
- R9: Each read port's 64-bit slice of `rd_pair` (bits 32p+31:32p) carries the register at the even index of the addressed pair in its upper 16 bits and the odd one in its lower 16 bits.
- R10: Each read port's 256-bit slice of `rd_group` (bits 256p+255:256p) holds, in word k, register base+k for k below the active count and zero above it. The count and base follow the pending prefix as a store would use it. In byte modes the upper byte of each word reads as zero.
- R11: When `pc_inc_en` is 1, the 32-bit value formed by registers 8 (high) and 9 (low) grows by `pc_inc`, with a carry from the low word into the high word. A write that touches register 8 or 9 in the same cycle takes precedence and suppresses the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_set | input | 1 | Load a size prefix for the next transfer |
| pfx_code | input | 3 | Size prefix code (0-3 words, 4-7 bytes) |
| wr_en | input | 1 | Write transfer strobe |
| wr_move | input | 1 | 1: register move, full words even under a byte code |
| wr_idx | input | 4 | Write start index (0-7 general, 8-15 pointer) |
| wr_data | input | 256 | Up to 16 words, word k for register base+k |
| rd_take | input | 1 | Store-read on port 0 consumes the prefix |
| rd_idx | input | 8 | Read index, 4 bits per port |
| pc_inc_en | input | 1 | Advance the program counter pair |
| pc_inc | input | 32 | Program counter increment amount |
| rd_word | output | 32 | Addressed word, 16 bits per port |
| rd_pair | output | 64 | Addressed 32-bit pair, 32 bits per port |
| rd_group | output | 512 | Prefix-sized group, 256 bits per port |
| align_err | output | 1 | Previous transfer index was misaligned |

## Verification
Assertions inside the design watch, on every cycle, the following rules:
- a register untouched by a write or an increment holds its value;
- byte loads preserve upper bytes;
- the program counter pair advances by the increment;
- the prefix lapses after one transfer;
- `align_err` follows the misalignment of the previous cycle's transfer.

The bench's scenarios are needed to show where the data lands: which word of the write bus reaches which register for every prefix, how a misaligned index is folded down, and that a write to register 8 or 9 overrides a concurrent increment. They also show what the pair and group outputs hold under word, byte and lapsed prefixes.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam int RF_W   = 16;
  localparam int RF_N   = 16;
  localparam int RF_IDX = $clog2(RF_N);
  localparam int RF_LEN = RF_IDX + 1;

  typedef struct packed {
    logic        active;
    logic [2:0]  code;
  } pfx_t;

  // number of registers one transfer covers
  function automatic logic [RF_LEN-1:0] xfer_len(pfx_t p, logic move);
    logic [RF_LEN-1:0] n;
    if (!p.active)         n = RF_LEN'(1);
    else if (!p.code[2])   n = RF_LEN'(2) << p.code[1:0];
    else                   n = RF_LEN'(1) << p.code[1:0];
    if (move) n = n;
    return n;
  endfunction

  // byte-lane transfer: only for memory loads and stores
  function automatic logic is_byte(pfx_t p, logic move);
    return p.active & p.code[2] & ~move;
  endfunction

  // clear the low bits of the index so the group starts on its size
  function automatic logic [RF_IDX-1:0] align_idx(logic [RF_IDX-1:0] idx,
                                                  logic [RF_LEN-1:0] len);
    logic [RF_LEN-1:0] m;
    m = len - RF_LEN'(1);
    return idx & ~m[RF_IDX-1:0];
  endfunction

  // true when register j lies in the group starting at base
  function automatic logic in_group(logic [RF_IDX-1:0] j,
                                    logic [RF_IDX-1:0] base,
                                    logic [RF_LEN-1:0] len);
    logic [RF_LEN-1:0] m;
    m = len - RF_LEN'(1);
    return (j & ~m[RF_IDX-1:0]) == base;
  endfunction
endpackage

// File: rtl/rf_prefix.sv
module rf_prefix
  import rfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set,
  input  logic [2:0] code,
  input  logic       consume,
  output pfx_t       cur
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (set) begin
      cur.active <= 1'b1;
      cur.code   <= code;
    end else if (consume) begin
      cur.active <= 1'b0;
    end
  end

  // R7: one transfer uses the prefix, after which it lapses
  assert_prefix_lapses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !set) |=> !cur.active);

  // R7: a new prefix is held for the following transfer
  assert_prefix_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> (cur.active && cur.code == $past(code)));
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rfp_pkg::*;
#(
  parameter int W    = RF_W,
  parameter int NREG = RF_N,
  localparam int IW  = $clog2(NREG),
  localparam int LW  = IW + 1,
  localparam int PC_HI = NREG / 2,
  localparam int PC_LO = NREG / 2 + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [IW-1:0]     wr_base,
  input  logic [LW-1:0]     wr_len,
  input  logic [NREG*W-1:0] wr_data,
  input  logic              pc_inc_en,
  input  logic [2*W-1:0]    pc_inc,
  output logic [NREG*W-1:0] regs_flat
);
  logic [W-1:0]   q   [NREG];
  logic [W-1:0]   nxt [NREG];
  logic [NREG-1:0] hit;
  logic [2*W-1:0] pc_sum;
  logic           pc_blocked;
  logic           pc_step;

  assign pc_sum     = {q[PC_HI], q[PC_LO]} + pc_inc;
  assign pc_blocked = hit[PC_HI] | hit[PC_LO];
  assign pc_step    = pc_inc_en & ~pc_blocked;

  always_comb begin
    for (int j = 0; j < NREG; j++) begin
      logic [IW-1:0] off;
      logic [W-1:0]  wd;
      off    = IW'(j) - wr_base;
      wd     = wr_data[int'(off)*W +: W];
      hit[j] = wr_en & in_group(IW'(j), wr_base, wr_len);
      nxt[j] = q[j];
      if (hit[j]) begin
        nxt[j] = wr_byte ? {q[j][W-1:W/2], wd[W/2-1:0]} : wd;
      end else if (pc_step && j == PC_HI) begin
        nxt[j] = pc_sum[2*W-1:W];
      end else if (pc_step && j == PC_LO) begin
        nxt[j] = pc_sum[W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NREG; j++) begin
      if (!rst_n) q[j] <= '0;
      else        q[j] <= nxt[j];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_flat[g*W +: W] = q[g];

    // R2: a register outside the write group and not advanced keeps its value
    assert_untouched_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[g] && !(pc_step && (g == PC_HI || g == PC_LO))) |=> $stable(q[g]));

    // R4: byte loads leave the upper byte alone
    assert_byte_keeps_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && wr_byte) |=> (q[g][W-1:W/2] == $past(q[g][W-1:W/2])));
  end

  // R11: unblocked increment advances the program counter pair
  assert_pc_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |=> ({q[PC_HI], q[PC_LO]} == $past({q[PC_HI], q[PC_LO]}) + $past(pc_inc)));
endmodule

// File: rtl/rf_readport.sv
module rf_readport
  import rfp_pkg::*;
#(
  parameter int W    = RF_W,
  parameter int NREG = RF_N,
  localparam int IW  = $clog2(NREG),
  localparam int LW  = IW + 1
)(
  input  logic [NREG*W-1:0] regs_flat,
  input  logic [IW-1:0]     idx,
  input  pfx_t              cur,
  output logic [W-1:0]      word,
  output logic [2*W-1:0]    pair,
  output logic [NREG*W-1:0] group
);
  logic [LW-1:0] len;
  logic [IW-1:0] base;
  logic          bmode;
  logic [IW-1:0] even;

  assign len   = xfer_len(cur, 1'b0);
  assign base  = align_idx(idx, len);
  assign bmode = is_byte(cur, 1'b0);
  assign even  = {idx[IW-1:1], 1'b0};

  assign word = regs_flat[int'(idx)*W +: W];
  assign pair = {regs_flat[int'(even)*W +: W], regs_flat[int'(even | IW'(1))*W +: W]};

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      logic [IW-1:0] src;
      logic [W-1:0]  v;
      src = base + IW'(k);
      v   = regs_flat[int'(src)*W +: W];
      if (LW'(k) >= len)  v = '0;
      else if (bmode)     v[W-1:W/2] = '0;
      group[k*W +: W] = v;
    end
  end

  // R9: the upper half of a pair is the even register of that pair
  always_comb begin
    if (!idx[0]) assert_pair_even_high_R9: assert (pair[2*W-1:W] == word);
  end

  // R10: with no prefix the group holds only the addressed word
  always_comb begin
    if (!cur.active) assert_group_single_R10: assert (group[W-1:0] == word);
  end
endmodule

// File: rtl/paired_regfile.sv
module paired_regfile
  import rfp_pkg::*;
#(
  parameter int W    = RF_W,
  parameter int NREG = RF_N,
  parameter int NRD  = 2,
  localparam int IW  = $clog2(NREG),
  localparam int LW  = IW + 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pfx_set,
  input  logic [2:0]            pfx_code,
  input  logic                  wr_en,
  input  logic                  wr_move,
  input  logic [IW-1:0]         wr_idx,
  input  logic [NREG*W-1:0]     wr_data,
  input  logic                  rd_take,
  input  logic [NRD*IW-1:0]     rd_idx,
  input  logic                  pc_inc_en,
  input  logic [2*W-1:0]        pc_inc,
  output logic [NRD*W-1:0]      rd_word,
  output logic [NRD*2*W-1:0]    rd_pair,
  output logic [NRD*NREG*W-1:0] rd_group,
  output logic                  align_err
);
  pfx_t              cur;
  logic [NREG*W-1:0] regs_flat;
  logic [LW-1:0]     wr_len;
  logic [IW-1:0]     wr_base;
  logic              wr_byte;
  logic [LW-1:0]     st_len;
  logic [IW-1:0]     st_base;
  logic              wr_misaligned;
  logic              st_misaligned;
  logic              misaligned;

  assign wr_len  = xfer_len(cur, wr_move);
  assign wr_base = align_idx(wr_idx, wr_len);
  assign wr_byte = is_byte(cur, wr_move);
  assign st_len  = xfer_len(cur, 1'b0);
  assign st_base = align_idx(rd_idx[IW-1:0], st_len);

  assign wr_misaligned = wr_en & (wr_idx != wr_base);
  assign st_misaligned = rd_take & (rd_idx[IW-1:0] != st_base);
  assign misaligned    = wr_misaligned | st_misaligned;

  rf_prefix u_pfx (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (pfx_set),
    .code    (pfx_code),
    .consume (wr_en | rd_take),
    .cur     (cur)
  );

  rf_storage #(.W(W), .NREG(NREG)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte),
    .wr_base   (wr_base),
    .wr_len    (wr_len),
    .wr_data   (wr_data),
    .pc_inc_en (pc_inc_en),
    .pc_inc    (pc_inc),
    .regs_flat (regs_flat)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_readport #(.W(W), .NREG(NREG)) u_rp (
      .regs_flat (regs_flat),
      .idx       (rd_idx[p*IW +: IW]),
      .cur       (cur),
      .word      (rd_word[p*W +: W]),
      .pair      (rd_pair[p*2*W +: 2*W]),
      .group     (rd_group[p*NREG*W +: NREG*W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) align_err <= 1'b0;
    else        align_err <= misaligned;
  end

  // R6: a misaligned transfer is flagged on the next cycle
  assert_misalign_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |=> align_err);

  // R6: an aligned or idle cycle leaves the flag low next cycle
  assert_aligned_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !misaligned |=> !align_err);
endmodule

// File: tb/sim_paired_regfile.sv
`timescale 1ns/1ps
module sim_paired_regfile;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pfx_set = 1'b0;
  logic [2:0]   pfx_code = '0;
  logic         wr_en = 1'b0;
  logic         wr_move = 1'b0;
  logic [3:0]   wr_idx = '0;
  logic [255:0] wr_data = '0;
  logic         rd_take = 1'b0;
  logic [3:0]   rd0 = '0;
  logic [3:0]   rd1 = '0;
  logic [7:0]   rd_idx;
  logic         pc_inc_en = 1'b0;
  logic [31:0]  pc_inc = '0;
  logic [31:0]  rd_word;
  logic [63:0]  rd_pair;
  logic [511:0] rd_group;
  logic         align_err;

  assign rd_idx = {rd1, rd0};
  always #2 clk = ~clk;

  paired_regfile u0 (
    .clk(clk), .rst_n(rst_n), .pfx_set(pfx_set), .pfx_code(pfx_code),
    .wr_en(wr_en), .wr_move(wr_move), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_take(rd_take), .rd_idx(rd_idx), .pc_inc_en(pc_inc_en), .pc_inc(pc_inc),
    .rd_word(rd_word), .rd_pair(rd_pair), .rd_group(rd_group), .align_err(align_err)
  );

  typedef struct { int idx; logic [15:0] val; string tag; } item_t;
  item_t       sbq[$];
  logic [15:0] mdl [16];
  logic        b_act = 1'b0;
  logic [2:0]  b_code = '0;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected register contents, reads them through port 1
  initial forever begin
    @(negedge clk);
    while (sbq.size() > 0) begin
      item_t it;
      it  = sbq.pop_front();
      rd1 = it.idx[3:0];
      #0.05;
      chk($sformatf("%s reg%0d", it.tag, it.idx), 256'(rd_word[31:16]), 256'(it.val));
    end
  end

  task automatic push_all(string tag);
    for (int i = 0; i < 16; i++) sbq.push_back('{i, mdl[i], tag});
    @(negedge clk);
    #1;
  endtask

  function automatic int blen(logic act, logic [2:0] c);
    if (!act) return 1;
    if (c < 3'd4) return 2 << c;
    return 1 << (c - 3'd4);
  endfunction

  function automatic logic [15:0] dword(int seed, int k);
    return 16'(seed + k * 16'h0111);
  endfunction

  task automatic set_pfx(logic [2:0] c);
    @(negedge clk);
    pfx_set = 1'b1; pfx_code = c;
    @(posedge clk); #1;
    pfx_set = 1'b0;
    b_act = 1'b1; b_code = c;
  endtask

  // write transfer; also_pfx loads a new prefix in the same cycle
  task automatic do_write(int idx, logic mv, int seed, logic exp_err, string tag,
                          logic also_pfx = 1'b0, logic [2:0] new_code = 3'd0,
                          logic inc = 1'b0, logic [31:0] inc_by = 32'd0);
    int n, base;
    logic byt;
    logic [31:0] pcv;
    n    = blen(b_act, b_code);
    base = idx - (idx % n);
    byt  = b_act && b_code[2] && !mv;
    @(negedge clk);
    for (int k = 0; k < 16; k++) wr_data[k*16 +: 16] = dword(seed, k);
    wr_en = 1'b1; wr_move = mv; wr_idx = 4'(idx);
    pfx_set = also_pfx; pfx_code = new_code;
    pc_inc_en = inc; pc_inc = inc_by;
    @(posedge clk); #1;
    wr_en = 1'b0; pfx_set = 1'b0; pc_inc_en = 1'b0;
    pcv = {mdl[8], mdl[9]} + inc_by;
    if (inc && !(base <= 9 && base + n > 8)) begin
      mdl[8] = pcv[31:16]; mdl[9] = pcv[15:0];
    end
    for (int k = 0; k < n; k++) begin
      if (byt) mdl[base+k][7:0] = dword(seed, k) & 16'h00ff;
      else     mdl[base+k] = dword(seed, k);
    end
    b_act = also_pfx; b_code = new_code;
    chk({tag, " align_err R6"}, 256'(align_err), 256'(exp_err));
    push_all(tag);
  endtask

  function automatic logic [255:0] exp_group(int idx);
    logic [255:0] g;
    int n, base;
    g = '0;
    n = blen(b_act, b_code);
    base = idx - (idx % n);
    for (int k = 0; k < n; k++) begin
      g[k*16 +: 16] = mdl[base+k];
      if (b_act && b_code[2]) g[k*16+8 +: 8] = 8'h00;
    end
    return g;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset contents and flag
    chk("R1 align_err", 256'(align_err), 256'(0));
    push_all("R1 reset");
    chk("R1 single group", rd_group[255:0], exp_group(0));

    // R2: single-word writes
    do_write(3, 0, 16'h1234, 0, "R2 single r3");
    do_write(12, 0, 16'hA0B0, 0, "R2 single mp4");

    // R3: word prefixes
    set_pfx(3'd0); do_write(4, 0, 16'h2200, 0, "R3 two words");
    set_pfx(3'd1); do_write(8, 0, 16'h4400, 0, "R3 four words");
    set_pfx(3'd2); do_write(0, 0, 16'h8800, 0, "R3 eight words");
    set_pfx(3'd3); do_write(0, 0, 16'hF000, 0, "R3 sixteen words");

    // R7: prefix lapses after one transfer
    do_write(6, 0, 16'h0606, 0, "R7 lapse to single");

    // R4: byte loads keep upper bytes
    set_pfx(3'd5); do_write(2, 0, 16'h55AA, 0, "R4 two bytes");
    set_pfx(3'd7); do_write(8, 0, 16'h3377, 0, "R4 eight bytes");
    set_pfx(3'd4); do_write(13, 0, 16'h1E1E, 0, "R4 one byte");

    // R5: move under byte code is full-word
    set_pfx(3'd6); do_write(4, 1, 16'hC0DE, 0, "R5 move four words");

    // R6: misaligned indices fold down and flag
    set_pfx(3'd1); do_write(6, 0, 16'hBAD0, 1, "R6 misaligned four");
    do_write(7, 0, 16'h0777, 0, "R6 single never misaligned");
    set_pfx(3'd2); do_write(13, 0, 16'h0D00, 1, "R6 misaligned eight");

    // R7: prefix loaded in the same cycle as a transfer
    do_write(1, 0, 16'h0101, 0, "R7 concurrent prefix", 1'b1, 3'd2);
    do_write(8, 0, 16'h0808, 0, "R7 deferred eight");

    // R8 and R9: word and pair reads
    @(negedge clk);
    rd0 = 4'd5; #0.1;
    chk("R8 word r5", 256'(rd_word[15:0]), 256'(mdl[5]));
    rd0 = 4'd11; #0.1;
    chk("R9 pair odd idx", 256'(rd_pair[31:0]), 256'({mdl[10], mdl[11]}));
    rd0 = 4'd14; #0.1;
    chk("R9 pair even idx", 256'(rd_pair[31:0]), 256'({mdl[14], mdl[15]}));

    // R10: group reads and R7 consumption by store-read
    set_pfx(3'd0);
    rd0 = 4'd5; #0.1;
    chk("R10 word group", rd_group[255:0], exp_group(5));
    set_pfx(3'd6);
    rd0 = 4'd0; #0.1;
    chk("R10 byte group", rd_group[255:0], exp_group(0));
    chk("R10 port1 group", rd_group[511:256], exp_group(int'(rd1)));
    @(negedge clk);
    rd0 = 4'd2; rd_take = 1'b1;
    @(posedge clk); #1;
    rd_take = 1'b0; b_act = 1'b0;
    chk("R6 misaligned store-read", 256'(align_err), 256'(1));
    #0.1;
    chk("R7 store-read consumed", rd_group[255:0], exp_group(2));

    // R11: program counter increment
    set_pfx(3'd0); do_write(8, 0, 16'h0000, 0, "R11 seed pc");
    do_write(12, 0, 16'h0C0C, 0, "R11 carry increment", 1'b0, 3'd0, 1'b1, 32'h0000_FFFF);
    do_write(9, 0, 16'h9999, 0, "R11 write beats increment", 1'b0, 3'd0, 1'b1, 32'h0000_0010);
    do_write(3, 0, 16'h0303, 0, "R11 plain increment", 1'b0, 3'd0, 1'b1, 32'h0001_0002);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule